// File: doc/BRIEF.md
# Delayed-Branch Issue Controller with Load Interlock

This block sits at the front of a short in-order pipeline and decides, every cycle, whether the instruction currently presented by the decoder may issue. It also owns the fetch address. Branches are delayed: the instruction placed right after a branch always issues, and only then does the fetch address move to the branch target. No instruction is flushed.

Loads are delayed as well. Issuing a load marks its destination register as busy in a per-register lock table. Later instructions keep issuing freely. Only an instruction that reads a busy register, or would overwrite one, is held back. The memory side releases a lock with a completion strobe that carries the register number. A strobe that arrives in the same cycle as the blocked instruction lets that instruction issue at once, with no bubble.

The decoder supplies the branch flag, the target, the load flag, the write flag, the destination and two source register numbers. The datapath, the memory and the decoder are not part of this block.

Top module: `slot_issue_ctrl`

## Requirements
- R1: While reset is active, and after it is released, the fetch address equals RESET_PC. No register is locked and no branch is pending.
- R2: When a non-branch instruction issues outside a delay slot, the fetch address becomes the current address plus one, wrapping modulo 2^AW.
- R3: When a branch issues, the fetch address first advances by one, to the delay slot. When the delay-slot instruction issues, the fetch address becomes the branch target.
- R4: If the instruction in a delay slot is itself a branch, slot_fault is 1 in the cycle it issues. Its target is ignored, and the fetch address still moves to the first branch's target.
- R5: An issued load locks its destination register. A later valid instruction whose src_a or src_b names a locked register gets stall=1 and issue=0.
- R6: An instruction that touches no locked register issues while a load is outstanding.
- R7: A valid instruction that writes a register (wr_en=1 or is_load=1) stalls when its dest is locked.
- R8: The completion strobe clears the lock only for the register it names. A strobe naming another register leaves a stall in place.
- R9: If the strobe clears the lock an instruction waits on, that instruction issues in the same cycle.
- R10: During a stall, the fetch address and any pending branch target are held unchanged.
- R11: With in_valid=0, issue and stall are both 0 and the fetch address is held.
- R12: If a load to register r issues in the same cycle as a completion strobe for r, r stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| is_branch | input | 1 | Instruction is a branch |
| br_target | input | AW | Branch target address |
| is_load | input | 1 | Instruction is a load |
| wr_en | input | 1 | Instruction writes dest |
| dest | input | RW | Destination register |
| src_a | input | RW | First source register |
| src_b | input | RW | Second source register |
| ld_done | input | 1 | Load completion strobe |
| ld_done_reg | input | RW | Register whose load completed |
| fetch_pc | output | AW | Address of the instruction presented |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction held by a lock |
| slot_fault | output | 1 | Branch issued in a delay slot |

## Verification
The bench builds the block with AW=8 and NREG=8. The narrow address lets a branch to 0xFF reach the fetch-address wrap to 0x00 within a short run. The small register file lets a handful of loads exercise locks on distinct registers, a completion strobe for the wrong register, and a load and a strobe for the same register in the same cycle. A directed reset in the middle of a pending branch, with a lock outstanding, shows that both are discarded.

// File: rtl/slot_issue_pkg.sv
package slot_issue_pkg;
  typedef enum logic {
    SEQ_RUN  = 1'b0,
    SEQ_SLOT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/lock_board.sv
module lock_board #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_reg,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_reg,
  output logic [NREG-1:0] lock_q,
  output logic [NREG-1:0] lock_view
);
  logic [NREG-1:0] lock_d;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = set_en && (set_reg == RW'(i));
    assign clr_hit = clr_en && (clr_reg == RW'(i));

    always_comb begin
      lock_d[i] = lock_q[i];
      if (set_hit)      lock_d[i] = 1'b1;
      else if (clr_hit) lock_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[i] <= 1'b0;
      else        lock_q[i] <= lock_d[i];
    end

    assign lock_view[i] = lock_q[i] && !clr_hit;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] lock_view,
  input  logic            in_valid,
  input  logic            writes,
  input  logic [RW-1:0]   dest,
  input  logic [RW-1:0]   src_a,
  input  logic [RW-1:0]   src_b,
  output logic            issue,
  output logic            stall
);
  logic raw_hit, waw_hit, hazard;

  always_comb begin
    raw_hit = lock_view[src_a] || lock_view[src_b];
    waw_hit = writes && lock_view[dest];
    hazard  = raw_hit || waw_hit;
    issue   = in_valid && !hazard;
    stall   = in_valid && hazard;
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import slot_issue_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          is_branch,
  input  logic [AW-1:0] br_target,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] tgt_q,
  output logic          slot_active,
  output logic          slot_fault
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] pc_d, tgt_d;
  logic          pc_en, tgt_en;

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q + AW'(1);
    tgt_d      = br_target;
    pc_en      = issue;
    tgt_en     = 1'b0;
    slot_fault = 1'b0;
    if (issue) begin
      if (state_q == SEQ_SLOT) begin
        pc_d       = tgt_q;
        state_d    = SEQ_RUN;
        slot_fault = is_branch;
      end else if (is_branch) begin
        tgt_en  = 1'b1;
        state_d = SEQ_SLOT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      pc_q    <= RESET_PC;
      tgt_q   <= RESET_PC;
    end else begin
      state_q <= state_d;
      if (pc_en)  pc_q  <= pc_d;
      if (tgt_en) tgt_q <= tgt_d;
    end
  end

  assign slot_active = (state_q == SEQ_SLOT);
endmodule

// File: rtl/slot_issue_ctrl.sv
module slot_issue_ctrl #(
  parameter int            AW       = 16,
  parameter int            NREG     = 32,
  parameter int            RW       = $clog2(NREG),
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          is_branch,
  input  logic [AW-1:0] br_target,
  input  logic          is_load,
  input  logic          wr_en,
  input  logic [RW-1:0] dest,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic          ld_done,
  input  logic [RW-1:0] ld_done_reg,
  output logic [AW-1:0] fetch_pc,
  output logic          issue,
  output logic          stall,
  output logic          slot_fault
);
  logic [1:0]      rst_sync;
  logic            rst_core_n;
  logic [NREG-1:0] lock_q, lock_view;
  logic [AW-1:0]   tgt_q;
  logic            slot_active;
  logic            writes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign writes = wr_en || is_load;

  lock_board #(.NREG(NREG), .RW(RW)) u_lock (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .set_en   (issue && is_load),
    .set_reg  (dest),
    .clr_en   (ld_done),
    .clr_reg  (ld_done_reg),
    .lock_q   (lock_q),
    .lock_view(lock_view)
  );

  hazard_unit #(.NREG(NREG), .RW(RW)) u_haz (
    .lock_view(lock_view),
    .in_valid (in_valid && rst_core_n),
    .writes   (writes),
    .dest     (dest),
    .src_a    (src_a),
    .src_b    (src_b),
    .issue    (issue),
    .stall    (stall)
  );

  pc_seq #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .issue      (issue),
    .is_branch  (is_branch),
    .br_target  (br_target),
    .pc_q       (fetch_pc),
    .tgt_q      (tgt_q),
    .slot_active(slot_active),
    .slot_fault (slot_fault)
  );
endmodule

// File: rtl/slot_issue_chk.sv
module slot_issue_chk #(
  parameter int AW   = 16,
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            issue,
  input logic            stall,
  input logic            slot_fault,
  input logic [AW-1:0]   fetch_pc,
  input logic [AW-1:0]   tgt_q,
  input logic            slot_active,
  input logic [NREG-1:0] lock_q
);
  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_pc) && $stable(tgt_q)));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !slot_active) |=> fetch_pc == $past(fetch_pc) + AW'(1));
  // R3
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && slot_active) |=> fetch_pc == $past(tgt_q));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!issue && !stall));
  // R4
  fault_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault |-> (issue && slot_active));
  // R5
  stall_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ($countones(lock_q) != 0 && !issue));
endmodule

bind slot_issue_ctrl slot_issue_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .in_valid   (in_valid),
  .issue      (issue),
  .stall      (stall),
  .slot_fault (slot_fault),
  .fetch_pc   (fetch_pc),
  .tgt_q      (tgt_q),
  .slot_active(slot_active),
  .lock_q     (lock_q)
);

// File: tb/slot_issue_ctrl_tb.sv
module slot_issue_ctrl_tb;
  localparam int AW = 8;
  localparam int NREG = 8;
  localparam int RW = 3;

  typedef struct packed {
    logic          v;
    logic          br;
    logic [AW-1:0] tgt;
    logic          ld;
    logic          wr;
    logic [RW-1:0] rd;
    logic [RW-1:0] ra;
    logic [RW-1:0] rb;
    logic          dn;
    logic [RW-1:0] dr;
    logic [3:0]    req;
    logic          e_iss;
    logic          e_stl;
    logic          e_flt;
    logic [AW-1:0] e_pc;
  } vec_t;

  localparam int NV = 32;
  // v br tgt ld wr rd ra rb dn dr req | iss stl flt pc
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd2,3'd3,1'b0,3'd0,4'd2, 1'b1,1'b0,1'b0,8'h00}, // R2
    '{1'b1,1'b0,8'h00,1'b1,1'b1,3'd4,3'd2,3'd0,1'b0,3'd0,4'd5, 1'b1,1'b0,1'b0,8'h01}, // R5 load r4
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd7,3'd5,3'd6,1'b0,3'd0,4'd6, 1'b1,1'b0,1'b0,8'h02}, // R6
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd4,3'd0,1'b0,3'd0,4'd5, 1'b0,1'b1,1'b0,8'h03}, // R5
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd4,3'd0,1'b0,3'd0,4'd10,1'b0,1'b1,1'b0,8'h03}, // R10
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd4,3'd0,1'b1,3'd4,4'd9, 1'b1,1'b0,1'b0,8'h03}, // R9
    '{1'b1,1'b1,8'h20,1'b0,1'b0,3'd0,3'd0,3'd0,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'h04}, // R3 branch
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd2,3'd3,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'h05}, // R3 slot
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd2,3'd3,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'h20}, // R3 target
    '{1'b1,1'b0,8'h00,1'b1,1'b1,3'd2,3'd0,3'd0,1'b0,3'd0,4'd5, 1'b1,1'b0,1'b0,8'h21}, // R5 load r2
    '{1'b1,1'b1,8'h40,1'b0,1'b0,3'd0,3'd2,3'd0,1'b0,3'd0,4'd5, 1'b0,1'b1,1'b0,8'h22}, // R5 branch waits
    '{1'b1,1'b1,8'h40,1'b0,1'b0,3'd0,3'd2,3'd0,1'b1,3'd3,4'd8, 1'b0,1'b1,1'b0,8'h22}, // R8 wrong reg
    '{1'b1,1'b1,8'h40,1'b0,1'b0,3'd0,3'd2,3'd0,1'b1,3'd2,4'd9, 1'b1,1'b0,1'b0,8'h22}, // R9
    '{1'b1,1'b1,8'h80,1'b0,1'b0,3'd0,3'd0,3'd0,1'b0,3'd0,4'd4, 1'b1,1'b0,1'b1,8'h23}, // R4 branch in slot
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd2,3'd3,1'b0,3'd0,4'd4, 1'b1,1'b0,1'b0,8'h40}, // R4 first target
    '{1'b1,1'b0,8'h00,1'b1,1'b1,3'd5,3'd0,3'd0,1'b0,3'd0,4'd5, 1'b1,1'b0,1'b0,8'h41}, // load r5
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd5,3'd0,3'd1,1'b0,3'd0,4'd7, 1'b0,1'b1,1'b0,8'h42}, // R7
    '{1'b0,1'b0,8'h00,1'b0,1'b1,3'd5,3'd0,3'd1,1'b0,3'd0,4'd11,1'b0,1'b0,1'b0,8'h42}, // R11
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd5,3'd0,3'd1,1'b1,3'd5,4'd9, 1'b1,1'b0,1'b0,8'h42}, // R9
    '{1'b1,1'b1,8'hFF,1'b0,1'b0,3'd0,3'd0,3'd0,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'h43}, // R3
    '{1'b1,1'b0,8'h00,1'b1,1'b1,3'd6,3'd0,3'd0,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'h44}, // slot load r6
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd2,3'd3,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'hFF}, // R3
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd6,3'd0,1'b0,3'd0,4'd2, 1'b0,1'b1,1'b0,8'h00}, // R2 wrap
    '{1'b1,1'b0,8'h00,1'b1,1'b1,3'd6,3'd0,3'd0,1'b1,3'd6,4'd12,1'b1,1'b0,1'b0,8'h00}, // R12
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd6,3'd0,1'b0,3'd0,4'd12,1'b0,1'b1,1'b0,8'h01}, // R12 still locked
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd6,3'd0,1'b1,3'd6,4'd8, 1'b1,1'b0,1'b0,8'h01}, // R8
    '{1'b1,1'b0,8'h00,1'b1,1'b1,3'd7,3'd0,3'd0,1'b0,3'd0,4'd5, 1'b1,1'b0,1'b0,8'h02}, // load r7
    '{1'b1,1'b1,8'h10,1'b0,1'b0,3'd0,3'd0,3'd0,1'b0,3'd0,4'd3, 1'b1,1'b0,1'b0,8'h03}, // branch
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd7,3'd0,1'b0,3'd0,4'd10,1'b0,1'b1,1'b0,8'h04}, // R10 slot stalls
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd7,3'd0,1'b0,3'd0,4'd10,1'b0,1'b1,1'b0,8'h04}, // R10
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd7,3'd0,1'b1,3'd7,4'd9, 1'b1,1'b0,1'b0,8'h04}, // R9
    '{1'b1,1'b0,8'h00,1'b0,1'b1,3'd1,3'd2,3'd3,1'b0,3'd0,4'd10,1'b1,1'b0,1'b0,8'h10}  // R10 target kept
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, is_branch, is_load, wr_en, ld_done;
  logic [AW-1:0] br_target;
  logic [RW-1:0] dest, src_a, src_b, ld_done_reg;
  logic [AW-1:0] fetch_pc;
  logic issue, stall, slot_fault;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  slot_issue_ctrl #(.AW(AW), .NREG(NREG), .RW(RW), .RESET_PC(8'h00)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_branch(is_branch),
    .br_target(br_target), .is_load(is_load), .wr_en(wr_en), .dest(dest),
    .src_a(src_a), .src_b(src_b), .ld_done(ld_done), .ld_done_reg(ld_done_reg),
    .fetch_pc(fetch_pc), .issue(issue), .stall(stall), .slot_fault(slot_fault)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    in_valid = t.v; is_branch = t.br; br_target = t.tgt; is_load = t.ld;
    wr_en = t.wr; dest = t.rd; src_a = t.ra; src_b = t.rb;
    ld_done = t.dn; ld_done_reg = t.dr;
  endtask

  task automatic idle();
    in_valid = 0; is_branch = 0; br_target = '0; is_load = 0; wr_en = 0;
    dest = '0; src_a = '0; src_b = '0; ld_done = 0; ld_done_reg = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    #1;
    check("R1", "pc in reset", fetch_pc, 0);
    check("R1", "stall in reset", stall, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "pc after release", fetch_pc, 0);
    check("R1", "issue idle", issue, 0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      @(negedge clk);
      drive(VEC[i]);
      #1;
      tg = $sformatf("R%0d row%0d", VEC[i].req, i);
      check(tg, "pc", fetch_pc, VEC[i].e_pc);
      check(tg, "issue", issue, VEC[i].e_iss);
      check(tg, "stall", stall, VEC[i].e_stl);
      check(tg, "slot_fault", slot_fault, VEC[i].e_flt);
    end

    // R1: reset discards an outstanding lock and a pending branch
    @(negedge clk);
    idle(); in_valid = 1; is_load = 1; dest = 3'd3;
    @(negedge clk);
    idle(); in_valid = 1; is_branch = 1; br_target = 8'h30;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    check("R1", "pc on async reset", fetch_pc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1; wr_en = 1; dest = 3'd1; src_a = 3'd3;
    #1;
    check("R1", "lock cleared issue", issue, 1);
    check("R1", "lock cleared stall", stall, 0);
    @(negedge clk);
    idle();
    #1;
    check("R1", "pending branch dropped", fetch_pc, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule